// File: doc/BRIEF.md
# Programmed I/O Cycle Sequencer for a Parallel Disk Interface

This block is the host-side engine that runs one programmed-I/O register access on a parallel disk bus. A client hands it a request: direction, a 5-bit device address, and write data. The block then drives the address lines, the read or write strobe and the 16-bit data bus, in the order and for the lengths that the selected transfer mode requires. It then reports completion with a one-cycle done pulse and, for reads, the returned data.

Five transfer modes (0 to 4) are supported. Each mode has nanosecond minimums for cycle time, address-to-strobe setup, strobe width, write-data hold and strobe recovery. These are converted to clock counts at elaboration from a clock-period parameter, always rounding up. A device may stretch a cycle by pulling its ready line low. The line is synchronised and looked at once, at the end of the nominal strobe. If it is low there, the strobe stays asserted until ready returns, or until a timeout aborts the access. The strobe polarity is selectable, and the data width follows the target register.

Top module: `pio_cycle_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `rsp_done` and `bus_oe` are 0, and both strobe pins sit at their inactive level (high when `strobe_act_high` is 0).
- R2: A request is accepted on a clock edge where `req_valid` is 1 and `busy` is 0, and `busy` is 1 from the next cycle. While busy, `req_valid` is ignored and `dev_addr` holds the accepted address until the cycle ends.
- R3: The strobe first asserts after S clock cycles of valid address, where S = ceil(t_setup/T). t_setup is 70, 50, 30, 30, 25 ns for modes 0..4 and T is `CLK_PERIOD_NS`.
- R4: With ready high at the decision point, the strobe stays asserted for P = ceil(t_pulse/T) cycles. t_pulse is 165, 125, 100, 80, 70 ns for modes 0..4.
- R5: On writes, `bus_dout` and `bus_oe` stay driven for H = ceil(t_hold/T) cycles after the strobe deasserts. t_hold is 30, 20, 15, 10, 10 ns for modes 0..4.
- R6: After the hold, a recovery phase of R = max(Rc - H, C - S - P - H, 0) cycles runs before `rsp_done`. C is ceil of the cycle time (600, 383, 240, 180, 120 ns). Rc is ceil of the recovery minimum, which is 70 ns in mode 3, 25 ns in mode 4 and 0 in modes 0..2. A `busy` cycle therefore lasts S+P+H+R cycles.
- R7: `iordy` passes through a 2-flop synchroniser and is judged only in the last nominal strobe cycle. A ready line that was low earlier but is high again by then adds no wait.
- R8: If the synchronised ready is low at the decision point, the strobe stays asserted. It drops on the third edge after `iordy` rises, and a read then returns the `bus_din` value present at that point.
- R9: A wait state lasting 1024 cycles (`WAIT_LIMIT`) with ready still low is aborted. The strobe width is then P+1024, the cycle completes normally, and `rsp_timeout` is 1 together with `rsp_done`.
- R10: With `strobe_act_high` at 1 the strobes are active-high, and with 0 they are active-low. At most one of the two strobes is active at a time.
- R11: Address 5'b10000 (chip-select pair 2'b10, register 0) transfers 16 bits. Any other address transfers 8 bits, with `bus_dout[15:8]` driven 0 on writes and `rsp_rdata[15:8]` returned 0 on reads.
- R12: `bus_oe` is 1 only in write cycles, from the first setup cycle through the last hold cycle, and is never 1 during a read.
- R13: `rsp_done` is a single-cycle pulse in the first idle cycle, with `rsp_rdata` valid for reads.
- R14: The mode is latched at acceptance, and a `mode_sel` value above 4 runs mode 4 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Transfer mode for the next request |
| strobe_act_high | input | 1 | 1: strobes active-high, 0: active-low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 5 | Chip-select pair and register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| dev_addr | output | 5 | Address lines to the device |
| dev_rd | output | 1 | Read strobe pin |
| dev_wr | output | 1 | Write strobe pin |
| bus_dout | output | 16 | Data bus output value |
| bus_oe | output | 1 | Data bus output enable |
| bus_din | input | 16 | Data bus input value |
| iordy | input | 1 | Device ready, asynchronous |
| rsp_done | output | 1 | Access complete pulse |
| rsp_rdata | output | 16 | Read data |
| rsp_timeout | output | 1 | Wait-state timeout on the finished access |

## Verification
The assertions take for granted that `iordy` and `bus_din` are only read through the synchroniser or at the capture point. They also take for granted that `mode_sel` and `strobe_act_high` are only looked at as levels, with no ordering implied against a request. The stimulus changes `iordy` and `bus_din` together, on the falling clock edge. It holds `strobe_act_high` constant across each access, and it keeps `bus_din` steady for at least two cycles before the engine captures it. This mirrors a device that drives valid data no later than it re-asserts ready.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int CNT_W = 12;
    localparam int MAX_MODE = 4;
    localparam logic [1:0] TASKFILE_CS = 2'b10;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_WAIT,
        PH_HOLD,
        PH_RECOV
    } phase_e;

    typedef struct packed {
        cnt_t setup;
        cnt_t pulse;
        cnt_t hold;
        cnt_t recov;
    } phase_len_t;

    typedef struct packed {
        logic [4:0]  addr;
        logic        write;
        logic        wide;
        logic [15:0] wdata;
    } access_t;

    function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    function automatic logic is_wide_reg(input logic [4:0] a);
        return a == {TASKFILE_CS, 3'b000};
    endfunction

    function automatic phase_len_t derive_len(input logic [2:0] mode, input int unsigned per);
        int unsigned cyc_ns, su_ns, pw_ns, hd_ns, rc_ns;
        int s, p, h, c, rc, r;
        phase_len_t res;
        case (mode)
            3'd0:    begin cyc_ns = 600; su_ns = 70; pw_ns = 165; hd_ns = 30; rc_ns = 0;  end
            3'd1:    begin cyc_ns = 383; su_ns = 50; pw_ns = 125; hd_ns = 20; rc_ns = 0;  end
            3'd2:    begin cyc_ns = 240; su_ns = 30; pw_ns = 100; hd_ns = 15; rc_ns = 0;  end
            3'd3:    begin cyc_ns = 180; su_ns = 30; pw_ns = 80;  hd_ns = 10; rc_ns = 70; end
            default: begin cyc_ns = 120; su_ns = 25; pw_ns = 70;  hd_ns = 10; rc_ns = 25; end
        endcase
        s  = int'(ns_to_clk(su_ns, per));
        p  = int'(ns_to_clk(pw_ns, per));
        h  = int'(ns_to_clk(hd_ns, per));
        c  = int'(ns_to_clk(cyc_ns, per));
        rc = int'(ns_to_clk(rc_ns, per));
        r  = rc - h;
        if (c - s - p - h > r) r = c - s - p - h;
        if (r < 0) r = 0;
        res.setup = CNT_W'(s);
        res.pulse = CNT_W'(p);
        res.hold  = CNT_W'(h);
        res.recov = CNT_W'(r);
        return res;
    endfunction

endpackage

// File: rtl/pio_mode_timing.sv
module pio_mode_timing
    import pio_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 20
) (
    input  logic [2:0] mode_i,
    output phase_len_t len_o
);
    // One row per mode; the live row is picked by the latched mode.
    phase_len_t table_q [MAX_MODE+1];

    for (genvar m = 0; m <= MAX_MODE; m++) begin : g_mode
        assign table_q[m] = derive_len(3'(m), CLK_PERIOD_NS);
    end

    always_comb begin
        if (mode_i > 3'(MAX_MODE)) len_o = table_q[MAX_MODE];
        else                       len_o = table_q[mode_i];
    end

    always_comb begin
        assert (len_o.setup != '0 && len_o.pulse != '0 && len_o.hold != '0)
            else $error("p_nonzero_phase_r3: a mandatory phase has zero length");
    end

endmodule

// File: rtl/pio_iordy_sync.sv
module pio_iordy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
    import pio_pkg::*;
#(
    parameter int WAIT_LIMIT = 1024,
    localparam int WW = $clog2(WAIT_LIMIT + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  phase_len_t len_i,
    input  logic       rdy_i,
    output phase_e     phase_o,
    output logic       capture_o,
    output logic       done_o,
    output logic       tout_o
);
    phase_e        phase_q;
    cnt_t          cnt_q;
    logic [WW-1:0] wcnt_q;
    logic          done_q;
    logic          tout_q;
    logic          last_cnt;

    assign last_cnt  = (cnt_q == '0);
    assign capture_o = ((phase_q == PH_PULSE) && last_cnt && rdy_i)
                     || ((phase_q == PH_WAIT) && rdy_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            wcnt_q  <= '0;
            done_q  <= 1'b0;
            tout_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= len_i.setup - 1'b1;
                        tout_q  <= 1'b0;
                    end
                end
                PH_SETUP: begin
                    if (last_cnt) begin
                        phase_q <= PH_PULSE;
                        cnt_q   <= len_i.pulse - 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (!last_cnt) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (rdy_i) begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= len_i.hold - 1'b1;
                    end else begin
                        phase_q <= PH_WAIT;
                        wcnt_q  <= '0;
                    end
                end
                PH_WAIT: begin
                    if (rdy_i) begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= len_i.hold - 1'b1;
                    end else if (wcnt_q == WW'(WAIT_LIMIT - 1)) begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= len_i.hold - 1'b1;
                        tout_q  <= 1'b1;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (!last_cnt) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (len_i.recov == '0) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        phase_q <= PH_RECOV;
                        cnt_q   <= len_i.recov - 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (last_cnt) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign done_o  = done_q;
    assign tout_o  = tout_q;

    p_start_enters_setup_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && start_i) |=> (phase_q == PH_SETUP));

    p_ready_ends_wait_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WAIT && rdy_i) |=> (phase_q == PH_HOLD));

    p_wait_bounded_r9: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WAIT) |-> (wcnt_q < WW'(WAIT_LIMIT)));

    p_done_single_r13: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    p_done_is_idle_r13: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (phase_q == PH_IDLE));

endmodule

// File: rtl/pio_bus_path.sv
module pio_bus_path
    import pio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        busy_i,
    input  logic        req_write_i,
    input  logic [4:0]  req_addr_i,
    input  logic [15:0] req_wdata_i,
    input  logic        capture_i,
    input  logic [15:0] bus_din_i,
    output logic [4:0]  addr_o,
    output logic        write_o,
    output logic [15:0] dout_o,
    output logic [15:0] rdata_o
);
    access_t     acc_q;
    logic [15:0] rdata_q;
    access_t     acc_next;

    always_comb begin
        acc_next.addr  = req_addr_i;
        acc_next.write = req_write_i;
        acc_next.wide  = is_wide_reg(req_addr_i);
        acc_next.wdata = acc_next.wide ? req_wdata_i : {8'h00, req_wdata_i[7:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (start_i) acc_q <= acc_next;
            if (capture_i && !acc_q.write)
                rdata_q <= acc_q.wide ? bus_din_i : {8'h00, bus_din_i[7:0]};
        end
    end

    assign addr_o  = acc_q.addr;
    assign write_o = acc_q.write;
    assign dout_o  = acc_q.wdata;
    assign rdata_o = rdata_q;

    p_addr_held_r2: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> $stable(acc_q.addr));

    p_narrow_upper_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !acc_q.wide |-> (acc_q.wdata[15:8] == 8'h00));

endmodule

// File: rtl/pio_cycle_engine.sv
module pio_cycle_engine
    import pio_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int          WAIT_LIMIT    = 1024,
    parameter int          SYNC_STAGES   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  mode_sel,
    input  logic        strobe_act_high,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_addr,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic [4:0]  dev_addr,
    output logic        dev_rd,
    output logic        dev_wr,
    output logic [15:0] bus_dout,
    output logic        bus_oe,
    input  logic [15:0] bus_din,
    input  logic        iordy,
    output logic        rsp_done,
    output logic [15:0] rsp_rdata,
    output logic        rsp_timeout
);
    phase_e     phase;
    phase_len_t len;
    logic [2:0] mode_q;
    logic [2:0] mode_eff;
    logic       start;
    logic       rdy_sync;
    logic       capture;
    logic       done;
    logic       tout;
    logic       wr_q;
    logic       strobe_on;
    logic       rd_act;
    logic       wr_act;

    assign busy     = (phase != PH_IDLE);
    assign start    = req_valid && !busy;
    assign mode_eff = start ? mode_sel : mode_q;

    always_ff @(posedge clk) begin
        if (rst)        mode_q <= '0;
        else if (start) mode_q <= mode_sel;
    end

    pio_mode_timing #(.CLK_PERIOD_NS(CLK_PERIOD_NS)) u_timing (
        .mode_i (mode_eff),
        .len_o  (len)
    );

    pio_iordy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (iordy),
        .sync_o  (rdy_sync)
    );

    pio_phase_fsm #(.WAIT_LIMIT(WAIT_LIMIT)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .len_i     (len),
        .rdy_i     (rdy_sync),
        .phase_o   (phase),
        .capture_o (capture),
        .done_o    (done),
        .tout_o    (tout)
    );

    pio_bus_path u_path (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .busy_i      (busy),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .capture_i   (capture),
        .bus_din_i   (bus_din),
        .addr_o      (dev_addr),
        .write_o     (wr_q),
        .dout_o      (bus_dout),
        .rdata_o     (rsp_rdata)
    );

    assign strobe_on = (phase == PH_PULSE) || (phase == PH_WAIT);
    assign rd_act    = strobe_on && !wr_q;
    assign wr_act    = strobe_on && wr_q;
    assign dev_rd    = strobe_act_high ? rd_act : !rd_act;
    assign dev_wr    = strobe_act_high ? wr_act : !wr_act;
    assign bus_oe    = wr_q && (phase inside {PH_SETUP, PH_PULSE, PH_WAIT, PH_HOLD});

    assign rsp_done    = done;
    assign rsp_timeout = done && tout;

    p_oe_only_writes_r12: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> wr_q);

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_act, wr_act}));

    p_timeout_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_timeout |-> rsp_done);

    p_mode_latched_r14: assert property (@(posedge clk) disable iff (rst)
        (busy && !$rose(busy)) |-> $stable(mode_q));

endmodule

// File: tb/pio_cycle_engine_tb.sv
`timescale 1ns/1ps
module pio_cycle_engine_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  mode_sel;
    logic        strobe_act_high;
    logic        req_valid;
    logic        req_write;
    logic [4:0]  req_addr;
    logic [15:0] req_wdata;
    logic        busy;
    logic [4:0]  dev_addr;
    logic        dev_rd;
    logic        dev_wr;
    logic [15:0] bus_dout;
    logic        bus_oe;
    logic [15:0] bus_din;
    logic        iordy;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        rsp_timeout;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    pio_cycle_engine u_dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .strobe_act_high(strobe_act_high),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .dev_addr(dev_addr), .dev_rd(dev_rd),
        .dev_wr(dev_wr), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
        .iordy(iordy), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .rsp_timeout(rsp_timeout)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic        wr;
        logic [4:0]  addr;
        logic [15:0] data;
        logic [11:0] s;
        logic [11:0] p;
        logic [11:0] h;
        logic [11:0] t;
        logic [15:0] expv;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b1, 5'b10000, 16'hA5C3, 12'd4, 12'd9, 12'd2, 12'd30, 16'hA5C3},
        '{3'd1, 1'b0, 5'b10000, 16'h1234, 12'd3, 12'd7, 12'd0, 12'd20, 16'h1234},
        '{3'd2, 1'b1, 5'b10001, 16'hBEEF, 12'd2, 12'd5, 12'd1, 12'd12, 16'h00EF},
        '{3'd3, 1'b0, 5'b10111, 16'h5A6B, 12'd2, 12'd4, 12'd0, 12'd10, 16'h006B},
        '{3'd4, 1'b1, 5'b01110, 16'h7777, 12'd2, 12'd4, 12'd1, 12'd8,  16'h0077},
        '{3'd7, 1'b0, 5'b10000, 16'hCAFE, 12'd2, 12'd4, 12'd0, 12'd8,  16'hCAFE},
        '{3'd0, 1'b0, 5'b00011, 16'hFFFF, 12'd4, 12'd9, 12'd0, 12'd30, 16'h00FF}
    };

    int          m_setup, m_pulse, m_hold, m_total, m_oe_rd, m_addr_bad;
    logic [15:0] m_dout, m_rdata;
    logic        m_tout;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Runs one access; iordy is driven high with din1 at pulse sample raise_at (0: never).
    task automatic run_cycle(input logic [2:0] mode, input logic wr, input logic [4:0] addr,
                             input logic [15:0] wd, input logic [15:0] din0,
                             input int raise_at, input logic [15:0] din1);
        int  n;
        logic seen, act;
        m_setup = 0; m_pulse = 0; m_hold = 0; m_total = 0; m_oe_rd = 0; m_addr_bad = 0;
        m_dout = '0; seen = 1'b0; n = 0;
        bus_din   = din0;
        mode_sel  = mode;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done && n < 5000) begin
            if (busy) m_total++;
            act = wr ? (dev_wr == strobe_act_high) : (dev_rd == strobe_act_high);
            if (act) begin
                m_pulse++;
                seen = 1'b1;
                if (m_pulse == raise_at) begin
                    iordy   = 1'b1;
                    bus_din = din1;
                end
                if (wr) m_dout = bus_dout;
            end else if (!seen) begin
                m_setup++;
            end else if (bus_oe) begin
                m_hold++;
            end
            if (!wr && bus_oe) m_oe_rd++;
            if (busy && dev_addr != addr) m_addr_bad++;
            n++;
            @(negedge clk);
        end
        m_rdata = rsp_rdata;
        m_tout  = rsp_timeout;
        chk("R13 done pulse seen", int'(rsp_done), 1);
        @(negedge clk);
        chk("R13 done single cycle", int'(rsp_done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        mode_sel = '0; strobe_act_high = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; bus_din = '0; iordy = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(rsp_done), 0);
        chk("R1 oe", int'(bus_oe), 0);
        chk("R1 rd idle high", int'(dev_rd), 1);
        chk("R1 wr idle high", int'(dev_wr), 1);

        // Vector table: R3 setup, R4 pulse, R5 hold, R6 total, R11 width, R12 oe, R14 mode
        for (int i = 0; i < NV; i++) begin
            run_cycle(VECS[i].mode, VECS[i].wr, VECS[i].addr, VECS[i].data,
                      VECS[i].data, 0, VECS[i].data);
            chk("R3 setup cycles", m_setup, int'(VECS[i].s));
            chk("R4 pulse cycles", m_pulse, int'(VECS[i].p));
            chk("R5 hold cycles", m_hold, int'(VECS[i].h));
            chk("R6 total cycles", m_total, int'(VECS[i].t));
            chk("R2 address held", m_addr_bad, 0);
            chk("R12 no oe on read", m_oe_rd, 0);
            if (VECS[i].wr) chk("R11 write data width", int'(m_dout), int'(VECS[i].expv));
            else            chk("R11 read data width", int'(m_rdata), int'(VECS[i].expv));
            chk("R9 no timeout", int'(m_tout), 0);
        end

        // R7: ready low before the strobe but restored in time adds no wait
        iordy = 1'b0;
        repeat (3) @(negedge clk);
        run_cycle(3'd4, 1'b0, 5'b10000, 16'h0, 16'h1111, 1, 16'h2222);
        chk("R7 restored in time pulse", m_pulse, 4);
        chk("R7 restored in time total", m_total, 8);

        // R8: ready low at the decision point stretches the strobe
        iordy = 1'b0;
        repeat (3) @(negedge clk);
        run_cycle(3'd4, 1'b0, 5'b10000, 16'h0, 16'h3333, 9, 16'h4444);
        chk("R8 stretched pulse", m_pulse, 11);
        chk("R8 stretched total", m_total, 15);
        chk("R8 read data at ready", int'(m_rdata), 16'h4444);

        // R9: wait-state timeout
        iordy = 1'b0;
        repeat (3) @(negedge clk);
        run_cycle(3'd4, 1'b1, 5'b10000, 16'h9876, 16'h0, 0, 16'h0);
        chk("R9 timeout flag", int'(m_tout), 1);
        chk("R9 aborted pulse", m_pulse, 4 + 1024);
        iordy = 1'b1;
        repeat (3) @(negedge clk);

        // R10: active-high strobes
        strobe_act_high = 1'b1;
        @(negedge clk);
        chk("R10 rd idle low", int'(dev_rd), 0);
        chk("R10 wr idle low", int'(dev_wr), 0);
        run_cycle(3'd4, 1'b0, 5'b10000, 16'h0, 16'h5555, 0, 16'h5555);
        chk("R10 active-high pulse", m_pulse, 4);
        strobe_act_high = 1'b0;
        @(negedge clk);

        // R2: request while busy is ignored
        mode_sel = 3'd2; req_write = 1'b1; req_addr = 5'b10010; req_wdata = 16'h00AA;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_addr = 5'b00101; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 address kept while busy", int'(dev_addr), 5'b10010);
        while (!rsp_done) @(negedge clk);
        @(negedge clk);
        chk("R2 no second access", int'(busy), 0);
        chk("R2 address after cycle", int'(dev_addr), 5'b10010);

        summary();
        $finish;
    end

endmodule